// File: doc/BRIEF.md
# Eye-Centering Bit Phase Aligner

This block finds the best sampling phase for a serial receiver whose incoming bitstream has no known phase relation to the local bit clock. It drives a tapped input delay line that spans one bit-clock period in 2^TAP_BITS steps (256 by default). The block walks the delay through every tap. At each tap it waits for the line to settle, then checks a burst of received samples for agreement. From the taps where the samples disagree it works out where the data eye lies, and it parks the delay on the tap in the middle of that eye.

A sweep starts with a start pulse. The block applies tap 0 with a one-cycle load pulse and then steps the line forward with one-cycle increment pulses. It reports the outcome with a done level and a locked or failure flag. Word-level alignment downstream must wait until done is high with locked set. That stage, the delay cell itself and the receiver flop are outside this block.

Top module: `eye_center_aligner`

## Requirements
- R1: While reset is held and in the first cycle after it, tapValue is 0, tapLoad and tapInc are low, and done, locked and alignFail are low.
- R2: A start pulse seen while the block is idle clears done, locked and alignFail. At the next edge it sets tapValue to 0 and raises tapLoad for exactly one cycle. A start pulse during a sweep has no effect.
- R3: A sweep visits taps 0 to 255 in order. It gives exactly 255 single-cycle tapInc pulses, and each pulse comes with tapValue one above its previous value.
- R4: After each tapLoad or tapInc pulse, sampleIn is ignored for SETTLE_CYCLES cycles, counting the cycle in which the pulse is high.
- R5: At each tap the block takes COMPARE_SAMPLES consecutive samples. The tap counts as a transition tap if any of them differ, and as a stable tap if all are equal.
- R6: Let L be the last tap of the first transition region, in sweep order, that is followed by a stable tap (tap 255 is followed by tap 0). Let T be the first transition tap after L, going round cyclically, and let D = (T - L) mod 256, where 0 means 256. The centre tap is (L + floor(D/2)) mod 256. With one transition region spanning taps s to s+n-1, this is (s + n - 1 + floor((257 - n)/2)) mod 256.
- R7: On success the block applies the centre tap with one more tapLoad pulse, giving two tapLoad pulses per sweep. When the settle interval has passed it raises done and locked, and tapValue then holds the centre tap.
- R8: If the sweep finds no transition tap, or no stable tap, the block raises done and alignFail, keeps locked low, and issues no second tapLoad.
- R9: tapLoad and tapInc are never high in the same cycle.
- R10: locked is only high while done is high. done, locked, alignFail and tapValue hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-clock-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| sampleIn | input | 1 | Receiver sample taken through the delay line |
| tapValue | output | TAP_BITS | Tap setting the delay line should hold |
| tapLoad | output | 1 | One-cycle pulse: delay line takes tapValue |
| tapInc | output | 1 | One-cycle pulse: delay line steps one tap up |
| done | output | 1 | Sweep finished, result valid |
| locked | output | 1 | Centre tap applied and settled |
| alignFail | output | 1 | Sweep found no usable eye |

## Verification
The assertions assume the delay line follows tapLoad and tapInc in the same cycle those pulses appear. They also assume that sampleIn is meaningless only inside the settle window. The bench model keeps to both. It holds a delay tap equal to tapValue. For every settle window it drives a fixed wrong value, and outside the window it drives a clean value for stable taps or a value that flips every cycle for transition taps. Any sample taken too early therefore turns a stable tap into a transition tap. Start is always a single-cycle pulse, and one extra pulse lands in the middle of a sweep.

// File: rtl/eye_align_pkg.sv
package eye_align_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_COMMIT,
    ST_RESOLVE
  } alignState_t;

  // strobes from control to datapath, at most a few set per cycle
  typedef struct packed {
    logic clrStats;    // forget previous sweep results
    logic loadZero;    // apply tap 0
    logic incTap;      // step to the next tap
    logic loadCentre;  // apply the computed centre tap
    logic settleTick;  // advance settle counter
    logic takeSample;  // capture/compare one sample
    logic commitTap;   // fold this tap's verdict into the statistics
    logic finishOk;    // raise done and locked
    logic finishFail;  // raise done and alignFail
  } ctlStrobes_t;

endpackage

// File: rtl/eye_align_datapath.sv
module eye_align_datapath
  import eye_align_pkg::*;
#(
  parameter int TAP_BITS        = 8,
  parameter int SETTLE_CYCLES   = 4,
  parameter int COMPARE_SAMPLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         str,
  input  logic                sampleIn,
  output logic [TAP_BITS-1:0] tapValue,
  output logic                tapLoad,
  output logic                tapInc,
  output logic                done,
  output logic                locked,
  output logic                alignFail,
  output logic                settleLast,
  output logic                sampleLast,
  output logic                tapLast,
  output logic                alignOk
);

  localparam int NUM_TAPS = 1 << TAP_BITS;
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam int SAMPLE_W = $clog2(COMPARE_SAMPLES + 1);

  logic [TAP_BITS-1:0] tapReg;
  logic [SETTLE_W-1:0] settleCnt;
  logic [SAMPLE_W-1:0] sampleCnt;
  logic                refBit;
  logic                mismatch;

  // sweep statistics
  logic                anyUnstable;
  logic                anyStable;
  logic                prevUnstable;
  logic                leadFound;
  logic                trailFound;
  logic [TAP_BITS-1:0] firstUnstable;
  logic [TAP_BITS-1:0] leadTap;
  logic [TAP_BITS-1:0] trailTap;

  // centre computation
  logic [TAP_BITS-1:0] leadEff;
  logic [TAP_BITS-1:0] trailEff;
  logic [TAP_BITS-1:0] gap;
  logic [TAP_BITS:0]   span;
  logic [TAP_BITS-1:0] centreTap;
  logic                tapChange;

  assign tapChange  = str.loadZero | str.incTap | str.loadCentre;
  assign settleLast = (settleCnt == SETTLE_W'(SETTLE_CYCLES - 1));
  assign sampleLast = (sampleCnt == SAMPLE_W'(COMPARE_SAMPLES - 1));
  assign tapLast    = (tapReg == TAP_BITS'(NUM_TAPS - 1));
  assign tapValue   = tapReg;

  // tap register and delay-line pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapReg  <= '0;
      tapLoad <= 1'b0;
      tapInc  <= 1'b0;
    end else begin
      tapLoad <= str.loadZero | str.loadCentre;
      tapInc  <= str.incTap;
      if (str.loadZero)        tapReg <= '0;
      else if (str.loadCentre) tapReg <= centreTap;
      else if (str.incTap)     tapReg <= tapReg + TAP_BITS'(1);
    end
  end

  // settle and sample counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
      sampleCnt <= '0;
    end else if (tapChange) begin
      settleCnt <= '0;
      sampleCnt <= '0;
    end else begin
      if (str.settleTick) settleCnt <= settleCnt + SETTLE_W'(1);
      if (str.takeSample) sampleCnt <= sampleCnt + SAMPLE_W'(1);
    end
  end

  // sample agreement check for the current tap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refBit   <= 1'b0;
      mismatch <= 1'b0;
    end else if (str.takeSample) begin
      if (sampleCnt == '0) begin
        refBit   <= sampleIn;
        mismatch <= 1'b0;
      end else if (sampleIn != refBit) begin
        mismatch <= 1'b1;
      end
    end
  end

  // transition statistics over the sweep
  always_ff @(posedge clk) begin
    if (!rstN || str.clrStats) begin
      anyUnstable   <= 1'b0;
      anyStable     <= 1'b0;
      prevUnstable  <= 1'b0;
      leadFound     <= 1'b0;
      trailFound    <= 1'b0;
      firstUnstable <= '0;
      leadTap       <= '0;
      trailTap      <= '0;
    end else if (str.commitTap) begin
      prevUnstable <= mismatch;
      if (mismatch) begin
        anyUnstable <= 1'b1;
        if (!anyUnstable) firstUnstable <= tapReg;
        if (leadFound && !trailFound) begin
          trailFound <= 1'b1;
          trailTap   <= tapReg;
        end
      end else begin
        anyStable <= 1'b1;
        if (prevUnstable && !leadFound) begin
          leadFound <= 1'b1;
          leadTap   <= tapReg - TAP_BITS'(1);
        end
      end
    end
  end

  // With both kinds of tap present and no lead seen, the transition taps
  // form a suffix of the sweep, so the region ends on the last tap.
  always_comb begin
    leadEff   = leadFound  ? leadTap  : TAP_BITS'(NUM_TAPS - 1);
    trailEff  = trailFound ? trailTap : firstUnstable;
    gap       = trailEff - leadEff;
    span      = (gap == '0) ? (TAP_BITS + 1)'(NUM_TAPS) : {1'b0, gap};
    centreTap = leadEff + span[TAP_BITS:1];
    alignOk   = anyUnstable & anyStable;
  end

  // result flags
  always_ff @(posedge clk) begin
    if (!rstN || str.clrStats) begin
      done      <= 1'b0;
      locked    <= 1'b0;
      alignFail <= 1'b0;
    end else if (str.finishOk) begin
      done   <= 1'b1;
      locked <= 1'b1;
    end else if (str.finishFail) begin
      done      <= 1'b1;
      alignFail <= 1'b1;
    end
  end

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(tapLoad && tapInc));

  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    tapInc |-> (tapValue == $past(tapValue) + TAP_BITS'(1)));

  p_tap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!tapLoad && !tapInc) |-> $stable(tapValue));

  p_lock_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> done);

  p_fail_nolock_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFail |-> !locked);

  p_sample_after_settle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (str.takeSample && sampleCnt == '0) |-> $past(settleLast));

endmodule

// File: rtl/eye_align_control.sv
module eye_align_control
  import eye_align_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        settleLast,
  input  logic        sampleLast,
  input  logic        tapLast,
  input  logic        alignOk,
  output ctlStrobes_t str
);

  alignState_t state;
  alignState_t stateNext;
  logic        finalPhase;
  logic        finalPhaseNext;

  always_comb begin
    str            = '0;
    stateNext      = state;
    finalPhaseNext = finalPhase;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          str.clrStats   = 1'b1;
          str.loadZero   = 1'b1;
          finalPhaseNext = 1'b0;
          stateNext      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        str.settleTick = 1'b1;
        if (settleLast) begin
          if (finalPhase) begin
            str.finishOk = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            stateNext = ST_SAMPLE;
          end
        end
      end
      ST_SAMPLE: begin
        str.takeSample = 1'b1;
        if (sampleLast) stateNext = ST_COMMIT;
      end
      ST_COMMIT: begin
        str.commitTap = 1'b1;
        if (tapLast) begin
          stateNext = ST_RESOLVE;
        end else begin
          str.incTap = 1'b1;
          stateNext  = ST_SETTLE;
        end
      end
      ST_RESOLVE: begin
        if (alignOk) begin
          str.loadCentre = 1'b1;
          finalPhaseNext = 1'b1;
          stateNext      = ST_SETTLE;
        end else begin
          str.finishFail = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      finalPhase <= 1'b0;
    end else begin
      state      <= stateNext;
      finalPhase <= finalPhaseNext;
    end
  end

  p_sample_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SAMPLE) |-> ($past(state) == ST_SAMPLE || $past(state) == ST_SETTLE));

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !str.loadZero);

  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.loadZero, str.incTap, str.loadCentre}));

endmodule

// File: rtl/eye_center_aligner.sv
module eye_center_aligner
  import eye_align_pkg::*;
#(
  parameter int TAP_BITS        = 8,
  parameter int SETTLE_CYCLES   = 4,
  parameter int COMPARE_SAMPLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sampleIn,
  output logic [TAP_BITS-1:0] tapValue,
  output logic                tapLoad,
  output logic                tapInc,
  output logic                done,
  output logic                locked,
  output logic                alignFail
);

  ctlStrobes_t str;
  logic        settleLast;
  logic        sampleLast;
  logic        tapLast;
  logic        alignOk;

  eye_align_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .settleLast (settleLast),
    .sampleLast (sampleLast),
    .tapLast    (tapLast),
    .alignOk    (alignOk),
    .str        (str)
  );

  eye_align_datapath #(
    .TAP_BITS        (TAP_BITS),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .COMPARE_SAMPLES (COMPARE_SAMPLES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .sampleIn   (sampleIn),
    .tapValue   (tapValue),
    .tapLoad    (tapLoad),
    .tapInc     (tapInc),
    .done       (done),
    .locked     (locked),
    .alignFail  (alignFail),
    .settleLast (settleLast),
    .sampleLast (sampleLast),
    .tapLast    (tapLast),
    .alignOk    (alignOk)
  );

endmodule

// File: tb/test_eye_center_aligner.sv
module test_eye_center_aligner;

  localparam int TAP_BITS = 8;
  localparam int SETTLE   = 4;
  localparam int SAMPLES  = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic                sampleIn = 1'b1;
  logic [TAP_BITS-1:0] tapValue;
  logic                tapLoad, tapInc, done, locked, alignFail;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    centre;
    bit    ok;
    string name;
  } expItem_t;
  expItem_t expQ[$];

  int  regionStart = 0;
  int  regionLen   = 0;
  int  incCnt = 0;
  int  loadCnt = 0;
  int  resultsSeen = 0;
  int  noiseLeft = 0;
  bit  toggler = 1'b0;
  bit  prevDone = 1'b0;

  always #10 clk = ~clk;

  eye_center_aligner #(
    .TAP_BITS(TAP_BITS), .SETTLE_CYCLES(SETTLE), .COMPARE_SAMPLES(SAMPLES)
  ) i_eye_center_aligner (
    .clk(clk), .rstN(rstN), .start(start), .sampleIn(sampleIn),
    .tapValue(tapValue), .tapLoad(tapLoad), .tapInc(tapInc),
    .done(done), .locked(locked), .alignFail(alignFail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit inRegion(input int tap);
    return ((tap - regionStart + 256) % 256) < regionLen;
  endfunction

  // delay line and receiver model: wrong value during settle windows,
  // flipping data on transition taps, clean 1 elsewhere
  initial forever begin
    @(negedge clk);
    toggler = ~toggler;
    if (tapLoad || tapInc) noiseLeft = SETTLE;
    if (noiseLeft > 0) begin
      sampleIn = 1'b0;
      noiseLeft--;
    end else begin
      sampleIn = inRegion(int'(tapValue)) ? toggler : 1'b1;
    end
  end

  // monitor: pulse counts and scoreboard compare on rising done
  initial forever begin
    @(negedge clk);
    if (tapInc)  incCnt++;
    if (tapLoad) loadCnt++;
    if (done && !prevDone) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(locked == e.ok, e.ok ? "R7" : "R8", {e.name, " locked"}, int'(locked), int'(e.ok));
        check(alignFail == !e.ok, "R8", {e.name, " alignFail"}, int'(alignFail), int'(!e.ok));
        if (e.ok)
          check(int'(tapValue) == e.centre, "R6", {e.name, " centre tap"}, int'(tapValue), e.centre);
      end
      resultsSeen++;
    end
    prevDone = done;
  end

  task automatic runRegion(input int s, input int len, input string name, input bit busyPoke);
    expItem_t e;
    int baseInc, baseLoad, baseSeen, guard;
    logic [TAP_BITS-1:0] heldTap;
    regionStart = s;
    regionLen   = len;
    e.ok     = (len > 0) && (len < 256);
    e.centre = e.ok ? (s + len - 1 + (257 - len) / 2) % 256 : 0;
    e.name   = name;
    expQ.push_back(e);
    baseInc  = incCnt;
    baseLoad = loadCnt;
    baseSeen = resultsSeen;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(tapLoad == 1'b1 && tapValue == '0, "R2", {name, " load of tap 0"}, int'(tapValue), 0);
    check(done == 1'b0 && locked == 1'b0, "R2", {name, " flags cleared"}, int'(done), 0);
    if (busyPoke) begin
      repeat (700) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (resultsSeen == baseSeen && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R7", {name, " sweep finished"}, guard, 0);
    check(incCnt - baseInc == 255, "R3", {name, " increment pulses"}, incCnt - baseInc, 255);
    check(loadCnt - baseLoad == (e.ok ? 2 : 1), e.ok ? "R7" : "R8", {name, " load pulses"},
          loadCnt - baseLoad, e.ok ? 2 : 1);
    heldTap = tapValue;
    repeat (20) @(negedge clk);
    check(done && tapValue == heldTap && locked == e.ok, "R10", {name, " result held"},
          int'(tapValue), int'(heldTap));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tapValue == '0 && !tapLoad && !tapInc, "R1", "reset tap and pulses", int'(tapValue), 0);
    check(!done && !locked && !alignFail, "R1", "reset flags", int'({done, locked, alignFail}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(tapValue == '0 && !tapLoad && !tapInc && !done, "R1", "first cycle after reset",
          int'(tapValue), 0);
    // R4/R5: eye inside the sweep, settle noise would break stable taps
    runRegion(100, 11, "mid region", 1'b0);
    // R6: region ending on the last tap
    runRegion(250, 6, "region at end", 1'b0);
    // R6: region wrapping through tap 0
    runRegion(250, 12, "wrapping region", 1'b0);
    // R5/R6: one transition tap only
    runRegion(37, 1, "single tap", 1'b0);
    runRegion(0, 30, "region at start", 1'b0);
    // R2: start during a sweep is ignored
    runRegion(200, 20, "busy start", 1'b1);
    // R8: no transitions, then no stable taps
    runRegion(0, 0, "no edge", 1'b0);
    runRegion(0, 256, "no eye", 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule